// File: doc/BRIEF.md
# Scrambled RAM Access Wrapper

This block sits between a CPU data bus and a single-port word RAM. It makes a memory dump harder to interpret. Every CPU word address is permuted by XOR with a 32-bit address mask before it reaches the RAM. Every written word is XORed with a 32-bit data mask and with the zero-extended logical CPU address before it is stored. Read data passes through the same two XORs, so the CPU always gets back the value it wrote. Because the logical address feeds into the data whitening, one value stored at two different addresses gives two different stored words.

The two masks are written through a small configuration port. Only privileged (firmware) mode may write them. In application mode the writes are dropped, and the masks can never be read back. Both masks reset to zero, so the mapping is the identity until firmware loads random values.

Top module: `scram_ram`

## Requirements
- R1: After reset both masks are zero, so the physical address equals the logical address and the stored word is the write data XORed with the zero-extended logical address. `mem_rvalid_o` is low during and after reset until a read is issued.
- R2: The physical RAM address is `mem_addr_i` XORed with the low ADDR_W bits of the address mask. The upper mask bits have no effect, so every access stays inside the RAM.
- R3: The stored word is the write data XORed with the data mask and with the logical (unpermuted) CPU address, zero-extended to DATA_W.
- R4: A read returns the stored word XORed with the data mask and with the logical read address, so a read under unchanged masks returns the value that was written.
- R5: `mem_rvalid_o` is high in exactly the cycle after a read request (`mem_req_i`=1, `mem_we_i`=0) and is low after a write or an idle cycle.
- R6: Bit i of `mem_be_i` enables write byte lane i (bits 8i+7..8i) at the physical address. Lanes whose enable is 0 keep their stored content.
- R7: A configuration write with `priv_i`=0 changes neither mask.
- R8: `cfg_rdata_o` reads as zero at all times, in both modes.
- R9: A mask written in cycle k applies from the first access issued after cycle k. An access issued in cycle k uses the old masks for both its address and its data.
- R10: Equal values written to two different logical addresses are stored as different words.
- R11: With `priv_i`=1 and `cfg_we_i`=1, `cfg_sel_i`=0 loads `cfg_wdata_i` into the address mask and `cfg_sel_i`=1 loads it into the data mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 1 | 1 = privileged (firmware) mode |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_sel_i | input | 1 | 0 = address mask, 1 = data mask |
| cfg_wdata_i | input | 32 | Mask write value |
| cfg_rdata_o | output | 32 | Mask read value, always zero |
| mem_req_i | input | 1 | CPU access request |
| mem_we_i | input | 1 | 1 = write, 0 = read |
| mem_be_i | input | DATA_W/8 | Byte-lane write enables |
| mem_addr_i | input | ADDR_W | Logical word address |
| mem_wdata_i | input | DATA_W | Write data |
| mem_rdata_o | output | DATA_W | Unscrambled read data |
| mem_rvalid_o | output | 1 | Read data valid |

## Verification
Mask writes are registered and affect the next access. A write request is stored at the clock edge that samples it. Read data and `mem_rvalid_o` are due one edge after the request, because the RAM output register and the captured read context update at that same edge. The bench drives inputs at falling edges and samples one falling edge after the request, half a cycle after the results settle. A bench model of the physical array predicts each read from the requirements. The same-cycle mask change is checked by issuing an access in the cycle of the mask write and comparing the result against the old masks.

// File: rtl/scram_pkg.sv
package scram_pkg;
    localparam int unsigned MASK_W = 32;

    typedef enum logic {
        SEL_ADDR = 1'b0,
        SEL_DATA = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic [MASK_W-1:0] amask;
        logic [MASK_W-1:0] dmask;
    } mask_set_t;

    typedef struct packed {
        logic              rvalid;
        logic [MASK_W-1:0] laddr;
        logic [MASK_W-1:0] dmask;
    } rd_ctx_t;
endpackage

// File: rtl/scram_cfg.sv
module scram_cfg
    import scram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic [MASK_W-1:0] cfg_wdata_i,
    output mask_set_t         masks_o
);
    mask_set_t masks_d, masks_q;

    always_comb begin
        masks_d = masks_q;
        if (cfg_we_i && priv_i) begin
            if (cfg_sel_e'(cfg_sel_i) == SEL_DATA) begin
                masks_d.dmask = cfg_wdata_i;
            end else begin
                masks_d.amask = cfg_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            masks_q <= '0;
        end else begin
            masks_q <= masks_d;
        end
    end

    assign masks_o = masks_q;
endmodule

// File: rtl/scram_xform.sv
module scram_xform
    import scram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] laddr_i,
    input  logic [MASK_W-1:0] amask_i,
    input  logic [MASK_W-1:0] dmask_i,
    output logic [ADDR_W-1:0] paddr_o,
    output logic [DATA_W-1:0] key_o
);
    logic unused_hi_mask;

    assign unused_hi_mask = ^amask_i[MASK_W-1:ADDR_W];
    assign paddr_o = laddr_i ^ amask_i[ADDR_W-1:0];
    assign key_o   = dmask_i[DATA_W-1:0] ^ DATA_W'(laddr_i);
endmodule

// File: rtl/scram_mem.sv
module scram_mem #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  we_i,
    input  logic                  re_i,
    input  logic [DATA_W/8-1:0]   be_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned LANES = DATA_W / 8;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int ln = 0; ln < LANES; ln++) begin
                if (be_i[ln]) begin
                    store[addr_i][ln*8 +: 8] <= wdata_i[ln*8 +: 8];
                end
            end
        end
        if (re_i) begin
            rdata_q <= store[addr_i];
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/scram_ram.sv
module scram_ram
    import scram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                priv_i,
    input  logic                cfg_we_i,
    input  logic                cfg_sel_i,
    input  logic [31:0]         cfg_wdata_i,
    output logic [31:0]         cfg_rdata_o,
    input  logic                mem_req_i,
    input  logic                mem_we_i,
    input  logic [DATA_W/8-1:0] mem_be_i,
    input  logic [ADDR_W-1:0]   mem_addr_i,
    input  logic [DATA_W-1:0]   mem_wdata_i,
    output logic [DATA_W-1:0]   mem_rdata_o,
    output logic                mem_rvalid_o
);
    mask_set_t         masks;
    logic [MASK_W-1:0] amask;
    logic [MASK_W-1:0] dmask;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] wr_key;
    logic [DATA_W-1:0] rd_key;
    logic [DATA_W-1:0] ram_rdata;
    logic [ADDR_W-1:0] unused_rd_paddr;
    logic              wr_en;
    logic              rd_en;
    rd_ctx_t           ctx_d, ctx_q;

    scram_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .priv_i     (priv_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i),
        .masks_o    (masks)
    );

    assign amask = masks.amask;
    assign dmask = masks.dmask;
    assign wr_en = mem_req_i && mem_we_i;
    assign rd_en = mem_req_i && !mem_we_i;

    scram_xform #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
        .laddr_i(mem_addr_i),
        .amask_i(amask),
        .dmask_i(dmask),
        .paddr_o(ram_addr),
        .key_o  (wr_key)
    );

    scram_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .we_i   (wr_en),
        .re_i   (rd_en),
        .be_i   (mem_be_i),
        .addr_i (ram_addr),
        .wdata_i(mem_wdata_i ^ wr_key),
        .rdata_o(ram_rdata)
    );

    always_comb begin
        ctx_d        = ctx_q;
        ctx_d.rvalid = rd_en;
        if (rd_en) begin
            ctx_d.laddr = MASK_W'(mem_addr_i);
            ctx_d.dmask = dmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    scram_xform #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rev (
        .laddr_i(ctx_q.laddr[ADDR_W-1:0]),
        .amask_i('0),
        .dmask_i(ctx_q.dmask),
        .paddr_o(unused_rd_paddr),
        .key_o  (rd_key)
    );

    logic unused_ctx_hi;
    assign unused_ctx_hi = ^ctx_q.laddr[MASK_W-1:ADDR_W];

    assign mem_rdata_o  = ram_rdata ^ rd_key;
    assign mem_rvalid_o = ctx_q.rvalid;
    assign cfg_rdata_o  = '0;
endmodule

// File: rtl/scram_ram_chk.sv
module scram_ram_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              priv_i,
    input logic              cfg_we_i,
    input logic              cfg_sel_i,
    input logic [31:0]       cfg_wdata_i,
    input logic              mem_req_i,
    input logic              mem_we_i,
    input logic              mem_rvalid_o,
    input logic [ADDR_W-1:0] mem_addr_i,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [31:0]       amask,
    input logic [31:0]       dmask
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (amask == '0 && dmask == '0));

    // R5
    rvalid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_i && !mem_we_i) |=> mem_rvalid_o);

    // R5
    rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid_o |-> $past(mem_req_i && !mem_we_i));

    // R7
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_i |=> ($stable(amask) && $stable(dmask)));

    // R11
    amask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i && cfg_we_i && !cfg_sel_i) |=> amask == $past(cfg_wdata_i));

    // R11
    dmask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i && cfg_we_i && cfg_sel_i) |=> dmask == $past(cfg_wdata_i));

    // R2
    addr_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i |-> ram_addr == (mem_addr_i ^ amask[ADDR_W-1:0]));
endmodule

bind scram_ram scram_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_i      (priv_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .mem_req_i   (mem_req_i),
    .mem_we_i    (mem_we_i),
    .mem_rvalid_o(mem_rvalid_o),
    .mem_addr_i  (mem_addr_i),
    .ram_addr    (ram_addr),
    .amask       (amask),
    .dmask       (dmask)
);

// File: tb/tb_scram_ram.sv
module tb_scram_ram;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_CA = 2'd2;
    localparam logic [1:0] OP_CD = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic        priv;
        logic [3:0]  be;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{OP_WR, 1'b1, 4'hF, 8'h10, 32'hA5A5_1234},
        '{OP_RD, 1'b1, 4'hF, 8'h10, 32'h0},
        '{OP_CA, 1'b1, 4'hF, 8'h00, 32'h1234_5633},
        '{OP_CD, 1'b1, 4'hF, 8'h00, 32'hDEAD_BEEF},
        '{OP_RD, 1'b1, 4'hF, 8'h23, 32'h0},
        '{OP_WR, 1'b0, 4'hF, 8'h05, 32'h1111_2222},
        '{OP_RD, 1'b0, 4'hF, 8'h05, 32'h0},
        '{OP_WR, 1'b0, 4'h2, 8'h05, 32'hFFFF_FFFF},
        '{OP_RD, 1'b0, 4'hF, 8'h05, 32'h0},
        '{OP_CA, 1'b0, 4'hF, 8'h00, 32'h0000_00FF},
        '{OP_RD, 1'b0, 4'hF, 8'h05, 32'h0},
        '{OP_CD, 1'b0, 4'hF, 8'h00, 32'h0000_1234},
        '{OP_RD, 1'b1, 4'hF, 8'h23, 32'h0},
        '{OP_WR, 1'b1, 4'h9, 8'h7F, 32'h0000_0000},
        '{OP_RD, 1'b1, 4'hF, 8'h7F, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          priv_i = 1'b0;
    logic          cfg_we_i = 1'b0;
    logic          cfg_sel_i = 1'b0;
    logic [31:0]   cfg_wdata_i = '0;
    logic [31:0]   cfg_rdata_o;
    logic          mem_req_i = 1'b0;
    logic          mem_we_i = 1'b0;
    logic [3:0]    mem_be_i = '0;
    logic [AW-1:0] mem_addr_i = '0;
    logic [DW-1:0] mem_wdata_i = '0;
    logic [DW-1:0] mem_rdata_o;
    logic          mem_rvalid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_am = '0;
    logic [31:0] m_dm = '0;
    logic [31:0] pm [256];

    always #10 clk = ~clk;

    scram_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_phys(input logic [7:0] a);
        return a ^ m_am[7:0];
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] enc;
        logic [7:0]  p;
        p   = m_phys(a);
        enc = d ^ m_dm ^ {24'h0, a};
        for (int ln = 0; ln < 4; ln++) begin
            if (be[ln]) pm[p][ln*8 +: 8] = enc[ln*8 +: 8];
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        return pm[m_phys(a)] ^ m_dm ^ {24'h0, a};
    endfunction

    task automatic m_cfg(input logic priv, input logic sel, input logic [31:0] d);
        if (priv) begin
            if (sel) m_dm = d; else m_am = d;
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        mem_req_i = 1'b1; mem_we_i = 1'b1; mem_be_i = be; mem_addr_i = a; mem_wdata_i = d;
        @(posedge clk); @(negedge clk);
        mem_req_i = 1'b0; mem_we_i = 1'b0;
        m_write(a, be, d);
        // R5: no valid after a write
        check(mem_rvalid_o == 1'b0, "R5", {31'h0, mem_rvalid_o}, 32'h0);
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [31:0] exp;
        exp = m_read(a);
        mem_req_i = 1'b1; mem_we_i = 1'b0; mem_addr_i = a;
        @(posedge clk); @(negedge clk);
        mem_req_i = 1'b0;
        check(mem_rvalid_o == 1'b1, "R5", {31'h0, mem_rvalid_o}, 32'h1);
        check(mem_rdata_o == exp, req, mem_rdata_o, exp);
    endtask

    task automatic do_cfg(input logic priv, input logic sel, input logic [31:0] d);
        priv_i = priv; cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(posedge clk); @(negedge clk);
        cfg_we_i = 1'b0; priv_i = 1'b0;
        m_cfg(priv, sel, d);
        // R8: masks never read back
        check(cfg_rdata_o == 32'h0, "R8", cfg_rdata_o, 32'h0);
    endtask

    initial begin
        logic [31:0] s1, s2, exp;
        for (int i = 0; i < 256; i++) pm[i] = '0;
        @(negedge clk);
        // R1: reset state
        check(mem_rvalid_o == 1'b0, "R1", {31'h0, mem_rvalid_o}, 32'h0);
        check(cfg_rdata_o == 32'h0, "R8", cfg_rdata_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_rvalid_o == 1'b0, "R1", {31'h0, mem_rvalid_o}, 32'h0);

        // Vector table: R1 R2 R3 R4 R6 R7 R11
        for (int v = 0; v < NV; v++) begin
            case (TBL[v].op)
                OP_WR: do_write(TBL[v].addr, TBL[v].be, TBL[v].data);
                OP_RD: do_read(TBL[v].addr, "R2/R3/R4/R6/R7");
                OP_CA: do_cfg(TBL[v].priv, 1'b0, TBL[v].data);
                default: do_cfg(TBL[v].priv, 1'b1, TBL[v].data);
            endcase
        end

        // R9: read issued in the cycle of a data mask write uses the old mask
        exp = m_read(8'h05);
        mem_req_i = 1'b1; mem_we_i = 1'b0; mem_addr_i = 8'h05;
        priv_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 1'b1; cfg_wdata_i = 32'h0;
        @(posedge clk); @(negedge clk);
        mem_req_i = 1'b0; cfg_we_i = 1'b0; priv_i = 1'b0;
        check(mem_rdata_o == exp, "R9", mem_rdata_o, exp);
        m_cfg(1'b1, 1'b1, 32'h0);
        do_read(8'h05, "R9");

        // R9: write issued in the cycle of an address mask write uses the old mask
        mem_req_i = 1'b1; mem_we_i = 1'b1; mem_be_i = 4'hF; mem_addr_i = 8'h40; mem_wdata_i = 32'h0BAD_F00D;
        priv_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 32'h0000_0001;
        @(posedge clk); @(negedge clk);
        mem_req_i = 1'b0; mem_we_i = 1'b0; cfg_we_i = 1'b0; priv_i = 1'b0;
        m_write(8'h40, 4'hF, 32'h0BAD_F00D);
        m_cfg(1'b1, 1'b0, 32'h0000_0001);
        do_read(8'h72, "R9");

        // R10: same value at two addresses is stored as two different words
        do_cfg(1'b1, 1'b0, 32'h0);
        do_cfg(1'b1, 1'b1, 32'h0);
        do_write(8'h01, 4'hF, 32'h5A5A_5A5A);
        do_write(8'h02, 4'hF, 32'h5A5A_5A5A);
        do_cfg(1'b1, 1'b0, 32'h0000_0003);
        mem_req_i = 1'b1; mem_we_i = 1'b0; mem_addr_i = 8'h02;
        @(posedge clk); @(negedge clk);
        s1 = mem_rdata_o ^ 32'h2;
        mem_addr_i = 8'h01;
        @(posedge clk); @(negedge clk);
        mem_req_i = 1'b0;
        s2 = mem_rdata_o ^ 32'h1;
        check(s1 == 32'h5A5A_5A5B, "R10", s1, 32'h5A5A_5A5B);
        check(s2 == 32'h5A5A_5A58, "R10", s2, 32'h5A5A_5A58);
        check(s1 != s2, "R10", s1, ~s2);

        // R5: idle cycle leaves valid low
        @(negedge clk);
        check(mem_rvalid_o == 1'b0, "R5", {31'h0, mem_rvalid_o}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule